// File: doc/BRIEF.md
# Dual-Channel Edge-Latched DAC Word Loader

This block is the digital front end of a two-channel 12-bit current-steering converter. Both channels share one parallel data bus and one active-low write strobe. Each channel has its own active-low select. When the strobe returns high, every channel whose select is low at that moment stores the bus word, so a single write can load one channel or both with the same value. The block samples the strobe, the selects and the bus with the system clock and finds the rising edge from those samples.

Each stored word is turned into switch controls for the analog array. The two top bits drive three equal coarse segments through a thermometer code. Each segment carries a quarter of full scale, which keeps the coarse steps monotonic. The ten low bits pass straight through to the binary ladder switches. Segment and ladder lines are registered together. Code zero selects no current, and all ones selects 4095/4096 of the reference, which the inverting output stage then negates.

A bus-timing monitor, counted in clock samples, watches every write. It flags data that settles too late before the edge, data that moves too soon after it, and a strobe low pulse that is too short. The write still completes when a flag is raised.

Top module: `dual_dac_loader`

## Requirements
- R1: A channel stores `bus_data` only on a rising edge of `wr_n` while its select is low. The edge is seen at clock k, the first clock that samples `wr_n` high after a low sample. The stored word and its switch lines are visible after clock k+1, and not before.
- R2: A channel whose select is high at the edge keeps its stored word. The other channel is loaded as normal.
- R3: When both selects are low at the edge, both channels store the same word.
- R4: Without a rising edge of `wr_n` (strobe held low or held high), or when both selects are high at the edge, no stored word changes, whatever the bus does.
- R5: The top two bits of a stored word map to the segment lines (bit 0 first) as 00→000, 01→001, 10→011, 11→111.
- R6: The ladder lines equal the low ten bits of the stored word. Segment and ladder lines of a channel change on the same clock as the stored word.
- R7: While `rst` is high at a clock edge, both stored words, all switch lines and all timing flags go to zero.
- R8: `timing_flags` bit 0 (setup) pulses for one cycle after an edge if the sampled bus changed within the last `SETUP_CYC` samples before or at the edge.
- R9: `timing_flags` bit 1 (hold) pulses if the sampled bus changes within `HOLD_CYC` samples after an edge.
- R10: `timing_flags` bit 2 (width) pulses after an edge preceded by fewer than `MIN_LOW_CYC` consecutive low samples of `wr_n`.
- R11: A write that raises any timing flag still stores the word sampled at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Shared write strobe; loads on its rising edge |
| sel_a_n | input | 1 | Channel A select, active low |
| sel_b_n | input | 1 | Channel B select, active low |
| bus_data | input | 12 | Shared data word |
| word_a | output | 12 | Stored word, channel A |
| seg_a | output | 3 | Coarse segment switches, channel A |
| lad_a | output | 10 | Binary ladder switches, channel A |
| word_b | output | 12 | Stored word, channel B |
| seg_b | output | 3 | Coarse segment switches, channel B |
| lad_b | output | 10 | Binary ladder switches, channel B |
| timing_flags | output | 3 | One-cycle pulses: bit 0 setup, bit 1 hold, bit 2 width |

## Verification
The capture of a word and the raising of a timing flag can happen on the same edge. The bench forces this on purpose: it changes the bus a few samples before the strobe rises, cuts the low pulse short, or moves the bus one sample after the edge. Each time it checks that the right flag bit pulsed and that the channels still hold exactly the word sampled at the edge. Clean random writes must raise no flag, while both selects low must fill both channels with one word.

// File: rtl/dacl_pkg.sv
package dacl_pkg;

    // Timing monitor result; packed so that setup sits in bit 0.
    typedef struct packed {
        logic width;
        logic hold;
        logic setup;
    } tflag_t;

endpackage

// File: rtl/dacl_front.sv
module dacl_front #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_n,
    input  logic          sel_a_n,
    input  logic          sel_b_n,
    input  logic [DW-1:0] bus_data,
    output logic          wr_lvl,
    output logic          rise,
    output logic [1:0]    load,
    output logic [DW-1:0] data_s,
    output logic          data_chg
);

    typedef struct packed {
        logic          wr;
        logic          wr_prev;
        logic          sa_n;
        logic          sb_n;
        logic [DW-1:0] data;
        logic [DW-1:0] data_prev;
    } front_t;

    front_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.wr        = wr_n;
        st_d.wr_prev   = st_q.wr;
        st_d.sa_n      = sel_a_n;
        st_d.sb_n      = sel_b_n;
        st_d.data      = bus_data;
        st_d.data_prev = st_q.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.wr        <= 1'b1;
            st_q.wr_prev   <= 1'b1;
            st_q.sa_n      <= 1'b1;
            st_q.sb_n      <= 1'b1;
            st_q.data      <= '0;
            st_q.data_prev <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_lvl   = st_q.wr;
    assign rise     = st_q.wr & ~st_q.wr_prev;
    assign load[0]  = rise & ~st_q.sa_n;
    assign load[1]  = rise & ~st_q.sb_n;
    assign data_s   = st_q.data;
    assign data_chg = (st_q.data != st_q.data_prev);

    AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        rise |-> wr_lvl && $past(!wr_lvl)); // R1

endmodule

// File: rtl/dacl_timing_mon.sv
module dacl_timing_mon
    import dacl_pkg::*;
#(
    parameter int SETUP_CYC   = 16,
    parameter int HOLD_CYC    = 2,
    parameter int MIN_LOW_CYC = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_lvl,
    input  logic   rise,
    input  logic   data_chg,
    output tflag_t flags
);

    localparam int AW = $clog2(SETUP_CYC + 1);
    localparam int LW = $clog2(MIN_LOW_CYC + 1);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [AW-1:0] AGE_MAX  = AW'(SETUP_CYC);
    localparam logic [LW-1:0] LOW_MAX  = LW'(MIN_LOW_CYC);
    localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_CYC);

    typedef struct packed {
        logic [AW-1:0] age;
        logic [LW-1:0] low;
        logic [HW-1:0] hold;
        tflag_t        fl;
    } mon_t;

    mon_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // stable-sample age of the bus, saturating
        if (data_chg)
            st_d.age = '0;
        else if (st_q.age != AGE_MAX)
            st_d.age = st_q.age + 1'b1;

        // consecutive low samples of the strobe, saturating
        if (wr_lvl)
            st_d.low = '0;
        else if (st_q.low != LOW_MAX)
            st_d.low = st_q.low + 1'b1;

        // hold window after an edge
        if (rise)
            st_d.hold = HOLD_MAX;
        else if (st_q.hold != '0)
            st_d.hold = st_q.hold - 1'b1;

        st_d.fl.setup = rise && (data_chg || (st_q.age < AGE_MAX));
        st_d.fl.width = rise && (st_q.low < LOW_MAX);
        st_d.fl.hold  = (st_q.hold != '0) && data_chg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.fl;

    AST_SETUP_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        flags.setup |-> $past(rise)); // R8
    AST_WIDTH_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        flags.width |-> $past(rise)); // R10
    AST_HOLD_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        flags.hold |-> $past(data_chg) && !$past(rise)); // R9

endmodule

// File: rtl/dacl_channel.sv
module dacl_channel #(
    parameter int DW       = 12,
    parameter int SEG_BITS = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [DW-1:0]               din,
    output logic [DW-1:0]               word,
    output logic [(1<<SEG_BITS)-2:0]    seg,
    output logic [DW-SEG_BITS-1:0]      lad
);

    localparam int NSEG = (1 << SEG_BITS) - 1;
    localparam int LDW  = DW - SEG_BITS;

    typedef struct packed {
        logic [DW-1:0]   word;
        logic [NSEG-1:0] seg;
        logic [LDW-1:0]  lad;
    } ch_t;

    ch_t st_d, st_q;

    function automatic logic [NSEG-1:0] to_therm(input logic [SEG_BITS-1:0] code);
        logic [NSEG-1:0] t;
        for (int i = 0; i < NSEG; i++)
            t[i] = (int'(code) > i);
        return t;
    endfunction

    always_comb begin
        st_d      = st_q;
        if (load)
            st_d.word = din;
        st_d.seg  = to_therm(st_d.word[DW-1 -: SEG_BITS]);
        st_d.lad  = st_d.word[LDW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;
    assign seg  = st_q.seg;
    assign lad  = st_q.lad;

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        load |=> word == $past(din)); // R1
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(word)); // R4
    AST_SEG_THERMO: assert property (@(posedge clk) disable iff (rst)
        $onehot({1'b0, seg} + 1'b1)); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (word == '0) && (seg == '0) && (lad == '0)); // R7

endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
    import dacl_pkg::*;
#(
    parameter int DW          = 12,
    parameter int SEG_BITS    = 2,
    parameter int SETUP_CYC   = 16,
    parameter int HOLD_CYC    = 2,
    parameter int MIN_LOW_CYC = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_n,
    input  logic                      sel_a_n,
    input  logic                      sel_b_n,
    input  logic [DW-1:0]             bus_data,
    output logic [DW-1:0]             word_a,
    output logic [(1<<SEG_BITS)-2:0]  seg_a,
    output logic [DW-SEG_BITS-1:0]    lad_a,
    output logic [DW-1:0]             word_b,
    output logic [(1<<SEG_BITS)-2:0]  seg_b,
    output logic [DW-SEG_BITS-1:0]    lad_b,
    output logic [2:0]                timing_flags
);

    localparam int NCH  = 2;
    localparam int NSEG = (1 << SEG_BITS) - 1;
    localparam int LDW  = DW - SEG_BITS;

    logic            wr_lvl, rise, data_chg;
    logic [NCH-1:0]  load;
    logic [DW-1:0]   data_s;
    tflag_t          flags;
    logic [DW-1:0]   word_arr [NCH];
    logic [NSEG-1:0] seg_arr  [NCH];
    logic [LDW-1:0]  lad_arr  [NCH];

    dacl_front #(.DW(DW)) i_front (
        .clk      (clk),
        .rst      (rst),
        .wr_n     (wr_n),
        .sel_a_n  (sel_a_n),
        .sel_b_n  (sel_b_n),
        .bus_data (bus_data),
        .wr_lvl   (wr_lvl),
        .rise     (rise),
        .load     (load),
        .data_s   (data_s),
        .data_chg (data_chg)
    );

    dacl_timing_mon #(
        .SETUP_CYC   (SETUP_CYC),
        .HOLD_CYC    (HOLD_CYC),
        .MIN_LOW_CYC (MIN_LOW_CYC)
    ) i_mon (
        .clk      (clk),
        .rst      (rst),
        .wr_lvl   (wr_lvl),
        .rise     (rise),
        .data_chg (data_chg),
        .flags    (flags)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dacl_channel #(.DW(DW), .SEG_BITS(SEG_BITS)) i_ch (
            .clk  (clk),
            .rst  (rst),
            .load (load[c]),
            .din  (data_s),
            .word (word_arr[c]),
            .seg  (seg_arr[c]),
            .lad  (lad_arr[c])
        );
    end

    assign word_a       = word_arr[0];
    assign seg_a        = seg_arr[0];
    assign lad_a        = lad_arr[0];
    assign word_b       = word_arr[1];
    assign seg_b        = seg_arr[1];
    assign lad_b        = lad_arr[1];
    assign timing_flags = flags;

    AST_BOTH_SAME: assert property (@(posedge clk) disable iff (rst)
        (load == 2'b11) |=> word_a == word_b); // R3
    AST_UNSELECTED_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (rise && !load[1]) |=> $stable(word_b)); // R2
    AST_FLAGGED_STILL_LOADS: assert property (@(posedge clk) disable iff (rst)
        (load[0] && data_chg) |=> word_a == $past(data_s)); // R11

endmodule

// File: tb/test_dual_dac_loader.sv
`timescale 1ns/1ps
module test_dual_dac_loader;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_n, sel_a_n, sel_b_n;
    logic [11:0] bus_data;
    logic [11:0] word_a, word_b;
    logic [2:0]  seg_a, seg_b;
    logic [9:0]  lad_a, lad_b;
    logic [2:0]  timing_flags;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [11:0] exp_a = '0, exp_b = '0;
    logic [2:0]  vacc = '0;

    always #2.5 clk = ~clk;

    dual_dac_loader i_dual_dac_loader (
        .clk(clk), .rst(rst), .wr_n(wr_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
        .bus_data(bus_data), .word_a(word_a), .seg_a(seg_a), .lad_a(lad_a),
        .word_b(word_b), .seg_b(seg_b), .lad_b(lad_b), .timing_flags(timing_flags)
    );

    function automatic logic [2:0] therm_exp(input logic [1:0] c);
        case (c)
            2'b00: return 3'b000;
            2'b01: return 3'b001;
            2'b10: return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        vacc = vacc | timing_flags;
    endtask

    task automatic check_outputs(input string req);
        check({req, " word_a"}, word_a, exp_a);
        check({req, " word_b"}, word_b, exp_b);
        check({req, " seg_a"},  seg_a,  therm_exp(exp_a[11:10]));
        check({req, " seg_b"},  seg_b,  therm_exp(exp_b[11:10]));
        check({req, " lad_a"},  lad_a,  exp_a[9:0]);
        check({req, " lad_b"},  lad_b,  exp_b[9:0]);
    endtask

    // Clean write: bus and selects set with the strobe going low, held past the edge.
    task automatic do_write(input logic sa, input logic sb, input logic [11:0] d);
        bus_data = d; sel_a_n = sa; sel_b_n = sb; wr_n = 1'b0;
        repeat (20) tick();
        wr_n = 1'b1;
        repeat (6) tick();
        sel_a_n = 1'b1; sel_b_n = 1'b1;
        if (!sa) exp_a = d;
        if (!sb) exp_b = d;
        tick();
    endtask

    initial begin
        #(5.0 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        if (!finished) $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [11:0] d;
        logic [1:0]  s;
        void'($urandom(32'd4242));
        rst = 1'b1; wr_n = 1'b1; sel_a_n = 1'b1; sel_b_n = 1'b1; bus_data = '0;
        repeat (4) @(negedge clk);
        // R7: reset state
        check_outputs("R7 reset");
        check("R7 flags", timing_flags, 3'b000);
        rst = 1'b0;
        repeat (20) tick();

        // R1/R6: exact latency of the store and of the switch lines
        bus_data = 12'hA5C; sel_a_n = 1'b0; wr_n = 1'b0;
        repeat (20) tick();
        wr_n = 1'b1;
        tick();                       // after clock k: not yet stored
        check("R1 early word_a", word_a, 12'h000);
        check("R6 early seg_a", seg_a, 3'b000);
        tick();                       // after clock k+1: stored
        check("R1 word_a", word_a, 12'hA5C);
        check("R6 seg_a", seg_a, therm_exp(2'b10));
        check("R6 lad_a", lad_a, 10'h25C);
        exp_a = 12'hA5C;
        repeat (5) tick();
        sel_a_n = 1'b1;
        tick();
        check("R8 clean flags", vacc, 3'b000);

        // R5: every coarse code on channel B
        for (int c = 0; c < 4; c++) begin
            do_write(1'b1, 1'b0, {c[1:0], 10'h155});
            check_outputs("R5 code");
        end

        // R3: both selects low
        do_write(1'b0, 1'b0, 12'h3C7);
        check_outputs("R3 dual");
        // R2: only A
        do_write(1'b0, 1'b1, 12'hFFF);
        check_outputs("R2 only A");

        // R4: bus activity with strobe held high, then held low, then rise with no select
        sel_a_n = 1'b0; sel_b_n = 1'b0;
        for (int i = 0; i < 8; i++) begin bus_data = 12'($urandom); tick(); end
        wr_n = 1'b0;
        for (int i = 0; i < 8; i++) begin bus_data = 12'($urandom); tick(); end
        sel_a_n = 1'b1; sel_b_n = 1'b1;
        tick();
        wr_n = 1'b1;
        repeat (6) tick();
        check_outputs("R4 no edge");

        // R8 + R11: bus moves 3 samples before the edge
        vacc = '0;
        bus_data = 12'h111; sel_b_n = 1'b0; wr_n = 1'b0;
        repeat (20) tick();
        bus_data = 12'h9E2;
        repeat (3) tick();
        wr_n = 1'b1;
        repeat (6) tick();
        sel_b_n = 1'b1; exp_b = 12'h9E2;
        tick();
        check("R8 setup flag", vacc, 3'b001);
        check_outputs("R11 setup");

        // R10 + R11: short low pulse
        vacc = '0;
        bus_data = 12'h6B3; sel_a_n = 1'b0;
        repeat (20) tick();
        wr_n = 1'b0;
        repeat (3) tick();
        wr_n = 1'b1;
        repeat (6) tick();
        sel_a_n = 1'b1; exp_a = 12'h6B3;
        tick();
        check("R10 width flag", vacc, 3'b100);
        check_outputs("R11 width");

        // R9 + R11: bus moves one sample after the edge
        vacc = '0;
        bus_data = 12'h2D4; sel_a_n = 1'b0; sel_b_n = 1'b0; wr_n = 1'b0;
        repeat (20) tick();
        wr_n = 1'b1;
        tick();
        bus_data = 12'hEEE;
        repeat (6) tick();
        sel_a_n = 1'b1; sel_b_n = 1'b1; exp_a = 12'h2D4; exp_b = 12'h2D4;
        tick();
        check("R9 hold flag", vacc, 3'b010);
        check_outputs("R11 hold");
        repeat (20) tick();

        // Random clean writes: R1 R2 R3 R4
        for (int n = 0; n < 150; n++) begin
            d = 12'($urandom);
            s = 2'($urandom);
            vacc = '0;
            do_write(s[0], s[1], d);
            check_outputs("R1 random");
            check("R8 random clean", vacc, 3'b000);
        end

        // R7: reset in the middle of operation
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        exp_a = '0; exp_b = '0;
        check_outputs("R7 mid reset");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule